// File: doc/BRIEF.md
# HDLC Frame Receiver with Per-Frame Status Queue

This block receives a bit-oriented serial stream, one bit per cycle in which the strobe `bit_en` is high, and turns it into bytes. It finds the flag pattern that opens and closes each frame. It removes the zero a transmitter inserts after five ones, and it recognises aborts and an idle line. Bytes leave on a one-cycle `byte_valid` pulse, least significant bit first, as they were sent. A DMA engine can take them as they arrive.

When a frame ends, the block writes one status word into a small queue. Software can read that queue later, independently of the data. The word holds the frame's byte count, a CRC-CCITT error flag, an abort flag, a length-overrun flag and a code for leftover bits. The leftover-bit code covers frames whose length is not a whole number of bytes.

The input `keep_crc` chooses how the two check bytes at the end of a frame are handled. They are either delivered like any other byte or held back. The byte count always includes them. Line decoding and clock recovery happen before this block.

Top module: `hdlc_frame_rx`

## Requirements
- R1: A flag (a zero, six ones, a zero) opens a frame and clears the byte count, bit count and CRC. Two flags with no complete byte between them add no status entry.
- R2: A received zero that follows exactly five ones is removed from the data. Every other data bit is assembled least significant bit first. Each completed byte appears on `byte_data` with `byte_valid` high for one cycle, in the cycle after the strobe whose bit completed it. The seven bits preceding any flag or abort are never data.
- R3: With `keep_crc` = 1, every completed byte of a frame is delivered. With `keep_crc` = 0, a byte is delivered only once two newer bytes of the same frame have completed. The last two bytes before a closing flag or an abort are therefore never delivered.
- R4: A closing flag ending a frame of at least 3 bytes pushes a status word with this layout: the byte count in bits CNT_W-1:0, CRC error at bit CNT_W, abort at CNT_W+1, overrun at CNT_W+2 and residue code at CNT_W+4:CNT_W+3. With the default CNT_W = 14 these are 13:0, 14, 15, 16 and 18:17. The count includes the two CRC bytes.
- R5: The CRC error bit is 0 only when the CRC over all data bits of the frame ends at 16'hF0B8. The CRC is reflected, polynomial 16'h8408, and preset to 16'hFFFF. This is the result of a frame that carries its complemented CRC low byte first.
- R6: A seventh consecutive one inside a frame with at least one complete byte pushes a word with the abort bit 1 and the CRC error and residue fields 0. It then ends the frame. Bytes received after it and before the next flag are neither delivered nor counted.
- R7: The residue code gives the data bits left over after the last whole byte at a closing flag: 0, 1 or 2 bits give codes 0, 1 and 2, and three or more give 3.
- R8: A frame closed by a flag with fewer than 3 complete bytes pushes no status word. A frame of exactly 3 bytes does push one.
- R9: The queue holds up to DEPTH words (default 10) and returns them in arrival order. `stat_valid` is high while it is not empty, and `stat_pop` removes the oldest word.
- R10: A word that arrives while the queue already holds DEPTH words is dropped. `stat_ovf` then goes high and stays high until reset.
- R11: A frame longer than 2^CNT_W-1 bytes reports a count of 2^CNT_W-1 with the overrun bit 1.
- R12: `line_idle` is high from the fifteenth consecutive one until the next zero.
- R13: During reset and after it, `byte_valid`, `stat_valid`, `stat_ovf` and `line_idle` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Received line bit |
| keep_crc | input | 1 | 1: deliver the CRC bytes as data; 0: hold them back |
| byte_valid | output | 1 | One-cycle pulse marking a delivered byte |
| byte_data | output | 8 | Delivered byte |
| line_idle | output | 1 | Fifteen or more ones in a row seen |
| stat_valid | output | 1 | Status queue is not empty |
| stat_pop | input | 1 | Remove the oldest status word |
| stat_word | output | CNT_W+5 | Oldest status word |
| stat_ovf | output | 1 | Sticky: a status word was dropped on a full queue |

## Verification
The hardest conditions to reach are the queue filling up and a frame outgrowing its byte counter. Both need long runs of well-formed frames with no reads in between. The bench overrides the count width to 6 bits so that a 72-byte frame overruns it. It also sends eleven frames of increasing length without popping, then drains the queue and checks the counts in order. Aborts are placed right after a zero bit, so every data byte has cleared the seven-bit flag look-behind before the run of ones starts. Data containing 0x7E and 0xFF forces inserted zeros inside frames.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   localparam logic [15:0] CRC_PRESET = 16'hFFFF;
   localparam logic [15:0] CRC_GOOD   = 16'hF0B8;
   localparam logic [15:0] CRC_POLY_R = 16'h8408;
   localparam int          STUFF_ONES = 5;
   localparam int          FLAG_ONES  = 6;
   localparam int          IDLE_ONES  = 15;
   localparam int          MIN_BYTES  = 3;

   // one bit of the reflected CCITT CRC
   function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b);
      logic [15:0] s;
      s = c >> 1;
      if (c[0] ^ b) s = s ^ CRC_POLY_R;
      return s;
   endfunction

   // leftover bit count to the 2-bit residue code
   function automatic logic [1:0] residue_code(input logic [2:0] n);
      return (n > 3'd3) ? 2'd3 : n[1:0];
   endfunction
endpackage

// File: rtl/hdlc_rx_front.sv
module hdlc_rx_front
   import hdlc_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic dat_vld,
   output logic dat_bit,
   output logic flag_seen,
   output logic abort_seen,
   output logic line_idle
);
   localparam int DLY = FLAG_ONES + 1;
   localparam int OW  = $clog2(IDLE_ONES + 1);
   localparam int FW  = $clog2(DLY + 1);

   logic [OW-1:0]  ones_q;
   logic [DLY-1:0] dly_q;
   logic [FW-1:0]  fill_q;
   logic           stuffed;
   logic           keep;

   always_comb begin
      flag_seen  = bit_en && !bit_in && (ones_q == OW'(FLAG_ONES));
      abort_seen = bit_en &&  bit_in && (ones_q == OW'(FLAG_ONES));
      stuffed    = bit_en && !bit_in && (ones_q == OW'(STUFF_ONES));
      keep       = bit_en && !flag_seen && !abort_seen && !stuffed;
      dat_vld    = keep && (fill_q == FW'(DLY));
      dat_bit    = dly_q[0];
      line_idle  = (ones_q == OW'(IDLE_ONES));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q <= '0;
         dly_q  <= '0;
         fill_q <= '0;
      end else if (bit_en) begin
         if (!bit_in)                          ones_q <= '0;
         else if (ones_q != OW'(IDLE_ONES))    ones_q <= ones_q + 1'b1;
         if (flag_seen || abort_seen) begin
            fill_q <= '0;
         end else if (keep) begin
            dly_q <= {bit_in, dly_q[DLY-1:1]};
            if (fill_q != FW'(DLY)) fill_q <= fill_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
   import hdlc_rx_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             keep_crc,
   input  logic             dat_vld,
   input  logic             dat_bit,
   input  logic             flag_seen,
   input  logic             abort_seen,
   output logic             byte_valid,
   output logic [7:0]       byte_data,
   output logic             push,
   output logic [CNT_W+4:0] push_word
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             in_frame_q, ovr_q, bv_q;
   logic [7:0]       sh_q, bd_q, hold0_q, hold1_q, new_byte;
   logic [2:0]       nbit_q;
   logic [1:0]       nhold_q;
   logic [CNT_W-1:0] cnt_q;
   logic [15:0]      crc_q;
   logic             take, close_ok;

   always_comb begin
      new_byte  = {dat_bit, sh_q[7:1]};
      take      = dat_vld && in_frame_q;
      close_ok  = in_frame_q && (ovr_q || (cnt_q >= CNT_W'(MIN_BYTES)));
      push      = (flag_seen && close_ok) ||
                  (abort_seen && in_frame_q && (ovr_q || (cnt_q != '0)));
      push_word = flag_seen ?
                  {residue_code(nbit_q), ovr_q, 1'b0, (crc_q != CRC_GOOD), cnt_q} :
                  {2'b00, ovr_q, 1'b1, 1'b0, cnt_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         ovr_q      <= 1'b0;
         bv_q       <= 1'b0;
         bd_q       <= '0;
         sh_q       <= '0;
         hold0_q    <= '0;
         hold1_q    <= '0;
         nbit_q     <= '0;
         nhold_q    <= '0;
         cnt_q      <= '0;
         crc_q      <= CRC_PRESET;
      end else begin
         bv_q <= 1'b0;
         if (flag_seen) begin
            in_frame_q <= 1'b1;
            nbit_q     <= '0;
            cnt_q      <= '0;
            ovr_q      <= 1'b0;
            crc_q      <= CRC_PRESET;
            nhold_q    <= '0;
         end else if (abort_seen) begin
            in_frame_q <= 1'b0;
            nhold_q    <= '0;
         end else if (take) begin
            crc_q  <= crc_next(crc_q, dat_bit);
            sh_q   <= new_byte;
            nbit_q <= nbit_q + 3'd1;
            if (nbit_q == 3'd7) begin
               if (cnt_q == CNT_MAX) ovr_q <= 1'b1;
               else                  cnt_q <= cnt_q + 1'b1;
               if (keep_crc) begin
                  bv_q <= 1'b1;
                  bd_q <= new_byte;
               end else begin
                  case (nhold_q)
                     2'd0: begin hold0_q <= new_byte; nhold_q <= 2'd1; end
                     2'd1: begin hold1_q <= new_byte; nhold_q <= 2'd2; end
                     default: begin
                        bv_q    <= 1'b1;
                        bd_q    <= hold0_q;
                        hold0_q <= hold1_q;
                        hold1_q <= new_byte;
                     end
                  endcase
               end
            end
         end
      end
   end

   assign byte_valid = bv_q;
   assign byte_data  = bd_q;
endmodule

// File: rtl/hdlc_stat_fifo.sv
module hdlc_stat_fifo #(
   parameter int W     = 19,
   parameter int DEPTH = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               push_word,
   input  logic                       pop,
   output logic                       not_empty,
   output logic [W-1:0]               head,
   output logic                       ovf,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0] cnt_q;
   logic          full, do_push, do_pop;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign full    = (cnt_q == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_q] <= push_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         ovf   <= 1'b0;
      end else begin
         if (do_push) wr_q <= wr_nx;
         if (do_pop)  rd_q <= rd_nx;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end

   assign not_empty = (cnt_q != '0);
   assign head      = mem_q[rd_q];
   assign level     = cnt_q;
endmodule

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx #(
   parameter int CNT_W = 14,
   parameter int DEPTH = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic             keep_crc,
   output logic             byte_valid,
   output logic [7:0]       byte_data,
   output logic             line_idle,
   output logic             stat_valid,
   input  logic             stat_pop,
   output logic [CNT_W+4:0] stat_word,
   output logic             stat_ovf
);
   localparam int SW    = CNT_W + 5;
   localparam int LVL_W = $clog2(DEPTH + 1);

   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must be at least 3");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic             dat_vld, dat_bit, flag_seen, abort_seen, push;
   logic [SW-1:0]    push_word;
   logic [LVL_W-1:0] fifo_level;

   hdlc_rx_front u_front (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .dat_vld(dat_vld), .dat_bit(dat_bit), .flag_seen(flag_seen),
      .abort_seen(abort_seen), .line_idle(line_idle)
   );

   hdlc_rx_frame #(.CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .keep_crc(keep_crc),
      .dat_vld(dat_vld), .dat_bit(dat_bit), .flag_seen(flag_seen),
      .abort_seen(abort_seen), .byte_valid(byte_valid), .byte_data(byte_data),
      .push(push), .push_word(push_word)
   );

   hdlc_stat_fifo #(.W(SW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
      .pop(stat_pop), .not_empty(stat_valid), .head(stat_word),
      .ovf(stat_ovf), .level(fifo_level)
   );
endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk #(
   parameter int DEPTH = 10,
   parameter int LVL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             byte_valid,
   input logic             line_idle,
   input logic             stat_valid,
   input logic             stat_pop,
   input logic             stat_ovf,
   input logic [LVL_W-1:0] fifo_level
);
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(DEPTH)); // R9
   AST_EMPTY_BY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_valid) |-> $past(stat_pop)); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_ovf |=> stat_ovf); // R10
   AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_ovf) |-> ($past(fifo_level) == LVL_W'(DEPTH))); // R10
   AST_BYTE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> $past(bit_en)); // R2
   AST_IDLE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      line_idle |-> !byte_valid); // R12
endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .byte_valid(byte_valid),
   .line_idle(line_idle), .stat_valid(stat_valid), .stat_pop(stat_pop),
   .stat_ovf(stat_ovf), .fifo_level(fifo_level)
);

// File: tb/hdlc_frame_rx_test.sv
`timescale 1ns/1ps
module hdlc_frame_rx_test;
   localparam int CNT_W = 6;
   localparam int DEPTH = 10;
   localparam int SW    = CNT_W + 5;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 0, rst_n = 0, bit_en = 0, bit_in = 0, keep_crc = 1, stat_pop = 0;
   logic byte_valid, line_idle, stat_valid, stat_ovf;
   logic [7:0] byte_data;
   logic [SW-1:0] stat_word;

   hdlc_frame_rx #(.CNT_W(CNT_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .keep_crc(keep_crc), .byte_valid(byte_valid), .byte_data(byte_data),
      .line_idle(line_idle), .stat_valid(stat_valid), .stat_pop(stat_pop),
      .stat_word(stat_word), .stat_ovf(stat_ovf)
   );

   always #2.5 clk = ~clk;

   int errors = 0, checks = 0, nbytes_seen = 0, tx_run = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[0] ^ b;
      c = c >> 1;
      return fb ? (c ^ 16'h8408) : c;
   endfunction

   // reference model
   int m_ones, m_bits;
   bit m_dly[$];
   bit m_in, m_ovf, e_bv;
   logic [15:0] m_crc;
   logic [7:0]  m_cur, e_bd;
   logic [7:0]  m_hold[$];
   logic [SW-1:0] m_fifo[$];

   task automatic m_push(input logic [SW-1:0] w);
      if (m_fifo.size() < DEPTH) m_fifo.push_back(w);
      else m_ovf = 1;
   endtask

   function automatic logic [SW-1:0] m_word(input bit ab);
      int nb, rb;
      logic [CNT_W-1:0] c;
      logic [1:0] rc;
      nb = m_bits / 8;
      rb = m_bits % 8;
      c  = (nb > CMAX) ? CNT_W'(CMAX) : CNT_W'(nb);
      rc = (rb > 3) ? 2'd3 : 2'(rb);
      if (ab) return {2'b00, nb > CMAX, 1'b1, 1'b0, c};
      return {rc, nb > CMAX, 1'b0, m_crc != 16'hF0B8, c};
   endfunction

   task automatic m_step(input bit b);
      if (!b && m_ones == 6) begin
         if (m_in && m_bits / 8 >= 3) m_push(m_word(0));
         m_in = 1; m_bits = 0; m_crc = 16'hFFFF;
         m_hold.delete(); m_dly.delete();
      end else if (b && m_ones == 6) begin
         if (m_in && m_bits >= 8) m_push(m_word(1));
         m_in = 0;
         m_hold.delete(); m_dly.delete();
      end else if (!(!b && m_ones == 5)) begin
         m_dly.push_back(b);
         if (m_dly.size() > 7) begin
            bit d;
            d = m_dly.pop_front();
            if (m_in) begin
               m_crc = crc_bit(m_crc, d);
               m_cur = {d, m_cur[7:1]};
               m_bits++;
               if (m_bits % 8 == 0) begin
                  if (keep_crc) begin
                     e_bv = 1; e_bd = m_cur;
                  end else begin
                     m_hold.push_back(m_cur);
                     if (m_hold.size() > 2) begin e_bv = 1; e_bd = m_hold.pop_front(); end
                  end
               end
            end
         end
      end
      m_ones = b ? ((m_ones < 15) ? m_ones + 1 : 15) : 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ones = 0; m_bits = 0; m_in = 0; m_ovf = 0; e_bv = 0;
         m_crc = 16'hFFFF; m_cur = 0; e_bd = 0;
         m_dly.delete(); m_hold.delete(); m_fifo.delete();
      end else begin
         bit had;
         e_bv = 0;
         had = m_fifo.size() > 0;
         if (bit_en) m_step(bit_in);
         if (stat_pop && had) void'(m_fifo.pop_front());
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 byte_valid", byte_valid, e_bv);
         if (e_bv) chk("R2 byte_data", byte_data, e_bd);
         if (byte_valid) nbytes_seen++;
         chk("R9 stat_valid", stat_valid, m_fifo.size() > 0);
         if (m_fifo.size() > 0) chk("R4 stat_word", stat_word, m_fifo[0]);
         chk("R10 stat_ovf", stat_ovf, m_ovf);
         chk("R12 line_idle", line_idle, m_ones == 15);
      end
   end

   task automatic send_bit(input bit b);
      @(negedge clk); bit_en = 1; bit_in = b;
      @(negedge clk); bit_en = 0;
   endtask

   task automatic send_data(input bit b);
      send_bit(b);
      tx_run = b ? tx_run + 1 : 0;
      if (tx_run == 5) begin send_bit(0); tx_run = 0; end
   endtask

   task automatic send_flag();
      send_bit(0);
      repeat (6) send_bit(1);
      send_bit(0);
      tx_run = 0;
   endtask

   task automatic send_frame(input logic [7:0] d[$], input bit fcs, input bit flip, input int extra);
      logic [7:0] q[$];
      logic [15:0] c;
      q = d;
      c = 16'hFFFF;
      foreach (d[i]) for (int k = 0; k < 8; k++) c = crc_bit(c, d[i][k]);
      if (fcs) begin
         c = ~c;
         if (flip) c[3] = ~c[3];
         q.push_back(c[7:0]);
         q.push_back(c[15:8]);
      end
      foreach (q[i]) for (int k = 0; k < 8; k++) send_data(q[i][k]);
      for (int k = 0; k < extra; k++) send_data(k % 2 == 0);
      send_flag();
   endtask

   task automatic pop_one();
      @(negedge clk); stat_pop = 1;
      @(negedge clk); stat_pop = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d[$];
      int nb0;
      repeat (3) @(negedge clk);
      chk("R13 byte_valid in reset", byte_valid, 0);
      chk("R13 stat_valid in reset", stat_valid, 0);
      chk("R13 stat_ovf in reset", stat_ovf, 0);
      chk("R13 line_idle in reset", line_idle, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R13 stat_valid after reset", stat_valid, 0);

      // idle line
      repeat (16) send_bit(1);
      chk("R12 idle after 16 ones", line_idle, 1);
      send_flag();
      chk("R12 idle cleared by zero", line_idle, 0);
      send_flag();
      @(negedge clk);
      chk("R1 back-to-back flags give no entry", stat_valid, 0);

      // good frame, CRC bytes delivered
      d = '{8'h11, 8'h7E, 8'hFF, 8'h00, 8'hA5};
      nb0 = nbytes_seen;
      send_frame(d, 1, 0, 0);
      @(negedge clk);
      chk("R3 keep_crc=1 byte total", nbytes_seen - nb0, 7);
      chk("R4 count with CRC bytes", stat_word[CNT_W-1:0], 7);
      chk("R5 good CRC", stat_word[CNT_W], 0);
      chk("R7 aligned residue", stat_word[CNT_W+4:CNT_W+3], 0);
      pop_one();

      // bad CRC, CRC bytes held back
      keep_crc = 0;
      nb0 = nbytes_seen;
      send_frame(d, 1, 1, 0);
      @(negedge clk);
      chk("R3 keep_crc=0 byte total", nbytes_seen - nb0, 5);
      chk("R5 bad CRC flagged", stat_word[CNT_W], 1);
      pop_one();
      keep_crc = 1;

      // residue
      d = '{8'h3C, 8'h81, 8'hF0, 8'h0F};
      send_frame(d, 1, 0, 3);
      @(negedge clk);
      chk("R7 three leftover bits", stat_word[CNT_W+4:CNT_W+3], 3);
      chk("R7 count with residue", stat_word[CNT_W-1:0], 6);
      pop_one();
      send_frame(d, 1, 0, 2);
      @(negedge clk);
      chk("R7 two leftover bits", stat_word[CNT_W+4:CNT_W+3], 2);
      pop_one();

      // short frames
      d = '{8'h55, 8'hAA};
      send_frame(d, 0, 0, 0);
      @(negedge clk);
      chk("R8 two-byte frame dropped", stat_valid, 0);
      d = '{8'h42};
      send_frame(d, 1, 0, 0);
      @(negedge clk);
      chk("R8 three-byte frame kept", stat_valid, 1);
      chk("R8 three-byte count", stat_word[CNT_W-1:0], 3);
      pop_one();

      // abort
      d = '{8'h12, 8'h34, 8'h56, 8'h78};
      foreach (d[i]) for (int k = 0; k < 8; k++) send_data(d[i][k]);
      send_bit(0);
      repeat (8) send_bit(1);
      tx_run = 0;
      @(negedge clk);
      chk("R6 abort entry present", stat_valid, 1);
      chk("R6 abort bit", stat_word[CNT_W+1], 1);
      chk("R6 abort count", stat_word[CNT_W-1:0], 4);
      chk("R6 abort CRC field clear", stat_word[CNT_W], 0);
      pop_one();
      nb0 = nbytes_seen;
      d = '{8'h99, 8'h88, 8'h77};
      send_frame(d, 0, 0, 0);
      @(negedge clk);
      chk("R6 bytes after abort not delivered", nbytes_seen - nb0, 0);
      chk("R6 no entry after abort", stat_valid, 0);

      // fill the queue past its depth
      for (int f = 1; f <= DEPTH + 1; f++) begin
         d.delete();
         for (int i = 0; i < f; i++) d.push_back(8'(f * 17 + i));
         send_frame(d, 1, 0, 0);
      end
      @(negedge clk);
      chk("R10 overflow flagged", stat_ovf, 1);
      for (int f = 1; f <= DEPTH; f++) begin
         chk("R9 order of entries", stat_word[CNT_W-1:0], f + 2);
         pop_one();
      end
      @(negedge clk);
      chk("R9 empty after DEPTH pops", stat_valid, 0);
      chk("R10 overflow stays set", stat_ovf, 1);

      // byte counter overrun
      d.delete();
      for (int i = 0; i < 70; i++) d.push_back(8'(i * 29 + 3));
      send_frame(d, 1, 0, 0);
      @(negedge clk);
      chk("R11 saturated count", stat_word[CNT_W-1:0], CMAX);
      chk("R11 overrun bit", stat_word[CNT_W+2], 1);
      pop_one();

      repeat (4) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule